// File: doc/BRIEF.md
# Interrupt-Sensing General-Purpose I/O Port

This block is a bank of general-purpose pins behind a small memory-mapped register port. Software stores a value to drive, selects the direction of every pin, and reads back both the value it stored and the levels actually seen on the pads. Incoming pad levels first pass through a two-stage synchronizer. The synchronized value feeds the readable pad status word and a per-pin event detector.

Every pin runs in one of five sense modes: low level, high level, rising edge, falling edge, or any transition. A 2-bit code selects among the first four. The codes are packed sixteen pins to a word, in two configuration words. A separate per-pin bit selects the any-transition mode and overrides the code. A detected event latches a sticky status bit, and software clears it by writing a one. The mask word gates the status bits onto two interrupt lines, one for the lower half of the pins and one for the upper half.

The port is a single-cycle register interface. A write takes effect on the clock edge on which `bus_wr` is sampled high. Reads are combinational from `bus_addr`. An access whose low two address bits are not zero is ignored and reads as zero.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the data, direction, mask, both configuration words and the any-transition word all read zero, `pin_oe` is zero and both interrupt lines are low.
- R2: `pin_out` equals the word stored at offset 0x00 and `pin_oe` equals the word stored at offset 0x04. Both read back at their own offsets, and `pin_oe` changes only after a write to 0x04.
- R3: Offset 0x08 reads the synchronized pad levels. A change on `pin_in` driven between two clock edges is visible there after the second following edge and not after the first. Writes to 0x08 have no effect.
- R4: When a pin's bit in the any-transition word (offset 0x1C) is 1, that pin's status is set by every change of its synchronized level in either direction. Its 2-bit code is ignored, so a steady level sets nothing.
- R5: Pins 0–15 take their sense code from offset 0x0C and pins 16–31 from offset 0x10, in bits [2k+1:2k] for k = pin mod 16. The codes are 0 low level, 1 high level, 2 rising edge and 3 falling edge.
- R6: An edge on `pin_in` sets the pin's status bit on the third clock edge after the change, and not earlier.
- R7: Writing offset 0x18 clears every status bit whose write-data bit is 1. Bits written with 0 keep their value, and a status bit stays set until it is cleared.
- R8: A pin in a level mode sets its status bit on every cycle its level is active. When a set and a clear of the same bit fall in the same cycle, the set wins, so a clear only takes hold once the level has gone.
- R9: `irq_lo` is the OR over pins 0–15 of status AND mask, and `irq_hi` is the same over pins 16–31. The mask is at offset 0x14, and a mask bit of 1 enables its pin.
- R10: The configuration words, the mask and the any-transition word read back exactly as written. Status reads at 0x18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pin_in | input | 32 | Asynchronous pad levels |
| pin_out | output | 32 | Value driven on the pins |
| pin_oe | output | 32 | Per-pin output enable (1 = drive) |
| irq_lo | output | 1 | Interrupt for pins 0–15 |
| irq_hi | output | 1 | Interrupt for pins 16–31 |

## Verification
The bench builds the port with its default of 32 pins. At that width the low and high configuration words and both interrupt halves are all in use, so a pin index on either side of the 15/16 boundary exercises the word selection and the bit packing. Directed cases pin down the synchronizer latency, the edge-to-status latency, set-over-clear for level pins and the any-transition override. Seeded random rounds then mix all five sense modes, random masks and random old and new pad words, and compare the status and interrupt lines against a bench model of each mode.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // byte address width of the register port
    localparam int REG_ADDR_W = 5;
    // address bits that select a word register
    localparam int SEL_LSB    = 2;
    localparam int SEL_W      = 3;

    // per-pin sense behaviour after the override bit is applied
    typedef enum logic [2:0] {
        SNS_LOW  = 3'd0,
        SNS_HIGH = 3'd1,
        SNS_RISE = 3'd2,
        SNS_FALL = 3'd3,
        SNS_ANY  = 3'd4
    } sense_e;

    // word registers, indexed by byte address / 4
    typedef enum logic [SEL_W-1:0] {
        RG_DATA  = 3'd0,
        RG_DIR   = 3'd1,
        RG_PAD   = 3'd2,
        RG_CFGLO = 3'd3,
        RG_CFGHI = 3'd4,
        RG_MASK  = 3'd5,
        RG_STAT  = 3'd6,
        RG_BOTH  = 3'd7
    } reg_sel_e;

    function automatic sense_e sense_of(input logic [1:0] code, input logic any);
        sense_e m;
        if (any) begin
            m = SNS_ANY;
        end else begin
            unique case (code)
                2'd0: m = SNS_LOW;
                2'd1: m = SNS_HIGH;
                2'd2: m = SNS_RISE;
                2'd3: m = SNS_FALL;
                default: m = SNS_LOW;
            endcase
        end
        return m;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;
    logic [W-1:0] last_q;

    // two flops against metastability, a third holds last cycle's value
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
            last_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
            last_q <= stab_q;
        end
    end

    assign q      = stab_q;
    assign q_prev = last_q;
endmodule

// File: rtl/gpio_sense_cell.sv
module gpio_sense_cell
    import gpio_irq_pkg::*;
(
    input  logic       cur,
    input  logic       prev,
    input  logic [1:0] code,
    input  logic       any,
    output logic       hit
);
    sense_e mode;

    always_comb begin
        mode = sense_of(code, any);
        unique case (mode)
            SNS_LOW:  hit = ~cur;
            SNS_HIGH: hit = cur;
            SNS_RISE: hit = cur & ~prev;
            SNS_FALL: hit = ~cur & prev;
            SNS_ANY:  hit = cur ^ prev;
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  reg_sel_e        sel,
    input  logic [NPIN-1:0] wdata,
    input  logic [NPIN-1:0] pad,
    input  logic [NPIN-1:0] hit,
    output logic [NPIN-1:0] data_q,
    output logic [NPIN-1:0] dir_q,
    output logic [NPIN-1:0] cfg_lo_q,
    output logic [NPIN-1:0] cfg_hi_q,
    output logic [NPIN-1:0] mask_q,
    output logic [NPIN-1:0] both_q,
    output logic [NPIN-1:0] stat_q,
    output logic [NPIN-1:0] rdata
);
    logic [NPIN-1:0] clr_vec;

    assign clr_vec = (wr_en && sel == RG_STAT) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q   <= '0;
            dir_q    <= '0;
            cfg_lo_q <= '0;
            cfg_hi_q <= '0;
            mask_q   <= '0;
            both_q   <= '0;
        end else if (wr_en) begin
            unique case (sel)
                RG_DATA:  data_q   <= wdata;
                RG_DIR:   dir_q    <= wdata;
                RG_CFGLO: cfg_lo_q <= wdata;
                RG_CFGHI: cfg_hi_q <= wdata;
                RG_MASK:  mask_q   <= wdata;
                RG_BOTH:  both_q   <= wdata;
                default: ;
            endcase
        end
    end

    // sticky status: detection beats a same-cycle write-one clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_vec) | hit;
        end
    end

    always_comb begin
        unique case (sel)
            RG_DATA:  rdata = data_q;
            RG_DIR:   rdata = dir_q;
            RG_PAD:   rdata = pad;
            RG_CFGLO: rdata = cfg_lo_q;
            RG_CFGHI: rdata = cfg_hi_q;
            RG_MASK:  rdata = mask_q;
            RG_STAT:  rdata = stat_q;
            RG_BOTH:  rdata = both_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [NPIN-1:0]       bus_wdata,
    output logic [NPIN-1:0]       bus_rdata,
    input  logic [NPIN-1:0]       pin_in,
    output logic [NPIN-1:0]       pin_out,
    output logic [NPIN-1:0]       pin_oe,
    output logic                  irq_lo,
    output logic                  irq_hi
);
    localparam int HALF = NPIN / 2;

    logic            addr_ok;
    reg_sel_e        sel;
    logic [NPIN-1:0] pad_q;
    logic [NPIN-1:0] pad_prev;
    logic [NPIN-1:0] hit;
    logic [NPIN-1:0] data_q;
    logic [NPIN-1:0] dir_q;
    logic [NPIN-1:0] cfg_lo_q;
    logic [NPIN-1:0] cfg_hi_q;
    logic [NPIN-1:0] mask_q;
    logic [NPIN-1:0] both_q;
    logic [NPIN-1:0] stat_q;
    logic [NPIN-1:0] bank_rdata;
    logic [NPIN-1:0] pend;

    assign addr_ok = (bus_addr[SEL_LSB-1:0] == '0);
    assign sel     = reg_sel_e'(bus_addr[SEL_LSB +: SEL_W]);

    gpio_in_sync #(.W(NPIN)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (pin_in),
        .q      (pad_q),
        .q_prev (pad_prev)
    );

    for (genvar p = 0; p < NPIN; p++) begin : g_pin
        logic [1:0] code;
        if (p < HALF) begin : g_lo
            assign code = cfg_lo_q[2*p +: 2];
        end else begin : g_hi
            assign code = cfg_hi_q[2*(p-HALF) +: 2];
        end
        gpio_sense_cell u_cell (
            .cur  (pad_q[p]),
            .prev (pad_prev[p]),
            .code (code),
            .any  (both_q[p]),
            .hit  (hit[p])
        );
    end

    gpio_reg_bank #(.NPIN(NPIN)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr & addr_ok),
        .sel      (sel),
        .wdata    (bus_wdata),
        .pad      (pad_q),
        .hit      (hit),
        .data_q   (data_q),
        .dir_q    (dir_q),
        .cfg_lo_q (cfg_lo_q),
        .cfg_hi_q (cfg_hi_q),
        .mask_q   (mask_q),
        .both_q   (both_q),
        .stat_q   (stat_q),
        .rdata    (bank_rdata)
    );

    assign bus_rdata = addr_ok ? bank_rdata : '0;
    assign pin_out   = data_q;
    assign pin_oe    = dir_q;
    assign pend      = stat_q & mask_q;
    assign irq_lo    = |pend[HALF-1:0];
    assign irq_hi    = |pend[NPIN-1:HALF];
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_wr,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic [NPIN-1:0]       bus_wdata,
    input logic [NPIN-1:0]       pin_in,
    input logic [NPIN-1:0]       pin_oe,
    input logic                  irq_lo,
    input logic                  irq_hi,
    input logic [NPIN-1:0]       pad,
    input logic [NPIN-1:0]       stat,
    input logic [NPIN-1:0]       mask,
    input logic [NPIN-1:0]       both
);
    logic            wr_dir;
    logic [NPIN-1:0] clr;

    assign wr_dir = bus_wr && (bus_addr == REG_ADDR_W'(4));
    assign clr    = (bus_wr && bus_addr == REG_ADDR_W'(24)) ? bus_wdata : '0;

    // R2
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dir |=> $stable(pin_oe));

    // R3
    pad_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (pad == $past(pin_in, 2)));

    // R4
    any_edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |->
        (((stat & ~$past(stat)) & $past(both) & ~($past(pad) ^ $past(pad, 2))) == '0));

    // R7
    sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(stat) & ~$past(clr) & ~stat) == '0));

    // R9
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> (!irq_lo && !irq_hi));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPIN(NPIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_in    (pin_in),
    .pin_oe    (pin_oe),
    .irq_lo    (irq_lo),
    .irq_hi    (irq_hi),
    .pad       (pad_q),
    .stat      (stat_q),
    .mask      (mask_q),
    .both      (both_q)
);

// File: tb/tb_gpio_irq_port.sv
module tb_gpio_irq_port;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          bus_wr;
    logic [4:0]    bus_addr;
    logic [NP-1:0] bus_wdata;
    logic [NP-1:0] bus_rdata;
    logic [NP-1:0] pin_in;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq_lo;
    logic          irq_hi;

    int errs   = 0;
    int checks = 0;
    bit done   = 0;

    always #10ns clk = ~clk;

    gpio_irq_port #(.NPIN(NP)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_lo(irq_lo), .irq_hi(irq_hi)
    );

    task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [NP-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [NP-1:0] d);
        bus_addr = a;
        #1ns;
        d = bus_rdata;
    endtask

    function automatic logic [1:0] code_of(input logic [NP-1:0] lo, input logic [NP-1:0] hi, input int i);
        return (i < NP/2) ? lo[2*i +: 2] : hi[2*(i-NP/2) +: 2];
    endfunction

    // status expected after old pads settled, a clear-all, then a change to nw
    function automatic logic [NP-1:0] exp_stat(input logic [NP-1:0] lo, input logic [NP-1:0] hi,
            input logic [NP-1:0] bo, input logic [NP-1:0] old, input logic [NP-1:0] nw);
        logic [NP-1:0] e;
        for (int i = 0; i < NP; i++) begin
            if (bo[i]) e[i] = old[i] ^ nw[i];
            else case (code_of(lo, hi, i))
                2'd0: e[i] = ~old[i] | ~nw[i];
                2'd1: e[i] = old[i] | nw[i];
                2'd2: e[i] = ~old[i] & nw[i];
                default: e[i] = old[i] & ~nw[i];
            endcase
        end
        return e;
    endfunction

    function automatic logic [NP-1:0] exp_level(input logic [NP-1:0] lo, input logic [NP-1:0] hi,
            input logic [NP-1:0] bo, input logic [NP-1:0] nw);
        logic [NP-1:0] e;
        for (int i = 0; i < NP; i++) begin
            if (bo[i]) e[i] = 1'b0;
            else case (code_of(lo, hi, i))
                2'd0: e[i] = ~nw[i];
                2'd1: e[i] = nw[i];
                default: e[i] = 1'b0;
            endcase
        end
        return e;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] v, lo, hi, bo, mk, old, nw, e;
        void'($urandom(32'd1234));
        rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; pin_in = '0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset values
        rd(5'h00, v); chk("R1 data", v, '0);
        rd(5'h04, v); chk("R1 dir", v, '0);
        rd(5'h0C, v); chk("R1 cfglo", v, '0);
        rd(5'h10, v); chk("R1 cfghi", v, '0);
        rd(5'h14, v); chk("R1 mask", v, '0);
        rd(5'h1C, v); chk("R1 both", v, '0);
        chk("R1 oe", pin_oe, '0);
        chk("R1 irq", {30'd0, irq_hi, irq_lo}, '0);

        // R2 data and direction
        wr(5'h00, 32'hA5A5_0F0F);
        wr(5'h04, 32'hFFFF_0000);
        chk("R2 pin_out", pin_out, 32'hA5A5_0F0F);
        chk("R2 pin_oe", pin_oe, 32'hFFFF_0000);
        rd(5'h00, v); chk("R2 data rd", v, 32'hA5A5_0F0F);
        rd(5'h04, v); chk("R2 dir rd", v, 32'hFFFF_0000);

        // R10 read back of configuration
        lo = $urandom; hi = $urandom; mk = $urandom; bo = $urandom;
        wr(5'h0C, lo); wr(5'h10, hi); wr(5'h14, mk); wr(5'h1C, bo);
        rd(5'h0C, v); chk("R10 cfglo", v, lo);
        rd(5'h10, v); chk("R10 cfghi", v, hi);
        rd(5'h14, v); chk("R10 mask", v, mk);
        rd(5'h1C, v); chk("R10 both", v, bo);

        // R3 pad latency and read-only pad word
        wr(5'h14, '0);
        pin_in = 32'h1234_8001;
        cyc(1);
        rd(5'h08, v); chk("R3 pad after one edge", v, '0);
        cyc(1);
        rd(5'h08, v); chk("R3 pad after two edges", v, 32'h1234_8001);
        wr(5'h08, 32'h0);
        rd(5'h08, v); chk("R3 pad write ignored", v, 32'h1234_8001);

        // R6 / R5 rising edge on pin 3 (low word) and pin 16 (high word)
        pin_in = '0; wr(5'h1C, '0);
        wr(5'h0C, 32'hAAAA_AAAA); wr(5'h10, 32'hAAAA_AAAA);
        wr(5'h14, 32'hFFFF_FFFF);
        cyc(4);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, v); chk("R7 clear all", v, '0);
        pin_in = 32'h0001_0008;
        cyc(2);
        rd(5'h18, v); chk("R6 not yet at edge two", v, '0);
        cyc(1);
        rd(5'h18, v); chk("R6 set at edge three", v, 32'h0001_0008);
        chk("R9 irq pair", {30'd0, irq_hi, irq_lo}, 32'd3);

        // R7 zero write keeps, one write clears
        wr(5'h18, 32'h0);
        rd(5'h18, v); chk("R7 zero write", v, 32'h0001_0008);
        wr(5'h18, 32'h0000_0008);
        rd(5'h18, v); chk("R7 single clear", v, 32'h0001_0000);
        chk("R9 lo drops", {31'd0, irq_lo}, '0);

        // R5 falling code on pin 16 (code 3 in bits 1:0 of high word)
        wr(5'h18, 32'hFFFF_FFFF);
        wr(5'h10, 32'hAAAA_AAAB);
        pin_in = '0; cyc(3);
        rd(5'h18, v); chk("R5 fall pin16", v, 32'h0001_0000);

        // R8 low level on pin 5: clear does not stick while level holds
        wr(5'h10, 32'hAAAA_AAAA);
        wr(5'h0C, 32'hAAAA_A2AA);
        cyc(2);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, v); chk("R8 level set wins", v, 32'h0000_0020);
        pin_in = 32'h0000_0020; cyc(4);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, v); chk("R8 clear after level gone", v, '0);

        // R4 any-transition override on pin 20 with high-level code
        wr(5'h10, 32'hAAAA_A9AA);
        wr(5'h1C, 32'h0010_0000);
        cyc(2); wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, v); chk("R4 steady level ignored", v, '0);
        pin_in = 32'h0010_0020; cyc(3);
        rd(5'h18, v); chk("R4 rise", v, 32'h0010_0000);
        wr(5'h18, 32'h0010_0000); cyc(2);
        rd(5'h18, v); chk("R4 high level not resetting", v, '0);
        pin_in = 32'h0000_0020; cyc(3);
        rd(5'h18, v); chk("R4 fall", v, 32'h0010_0000);

        // R9 mask gating
        wr(5'h14, 32'h0010_0000);
        chk("R9 hi only", {30'd0, irq_hi, irq_lo}, 32'd2);
        wr(5'h14, 32'h0000_FFFF);
        chk("R9 masked off", {30'd0, irq_hi, irq_lo}, 32'd0);

        // random rounds across all modes
        for (int r = 0; r < 40; r++) begin
            lo = $urandom; hi = $urandom; bo = $urandom & $urandom; mk = $urandom;
            old = $urandom; nw = $urandom;
            wr(5'h0C, lo); wr(5'h10, hi); wr(5'h1C, bo); wr(5'h14, mk);
            pin_in = old; cyc(4);
            wr(5'h18, 32'hFFFF_FFFF);
            pin_in = nw; cyc(4);
            e = exp_stat(lo, hi, bo, old, nw);
            rd(5'h18, v); chk("R5 R4 random status", v, e);
            chk("R9 random irq", {30'd0, irq_hi, irq_lo},
                {30'd0, |(e[31:16] & mk[31:16]), |(e[15:0] & mk[15:0])});
            wr(5'h18, 32'hFFFF_FFFF);
            rd(5'h18, v); chk("R8 random level persists", v, exp_level(lo, hi, bo, nw));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule